// File: doc/BRIEF.md
# Microsecond Timebase with Fractional Ratio Divider

This block turns a reference clock of any frequency into an exact one-microsecond time base. A ratio word holds a numerator and a denominator, each as "value minus one". On every reference cycle that is not frozen, the numerator is added to an accumulator. When the sum reaches the denominator, the block issues one tick and subtracts the denominator. Reference rates that are not whole multiples of 1 MHz, such as 19.2 MHz (ratio 5/96), therefore give exactly one tick per microsecond on average, with no long-term drift.

Each tick advances a free-running 32-bit up-counter, which wraps to zero after its maximum value. A one-cycle tick output feeds downstream timers. A small register port reads and writes the counter, the ratio word and a freeze control, and it returns read data one cycle after the request. Software keeps a copy of the ratio word across power-down and writes it back on wake-up, because the block holds no state through power loss.

Top module: `ustb_timebase`

## Requirements
- R1: After a synchronous active-high reset, the counter is 0, the ratio word is 0x000B (1/12, which suits a 12 MHz reference), freeze is 0, tick_o is 0 and rd_data_o is 0.
- R2: Each accumulator overflow raises tick_o for exactly one cycle. The counter shows its incremented value in that same cycle.
- R3: Ratio word bits [7:0] hold denominator−1 and bits [15:8] hold numerator−1. On each unfrozen cycle the numerator is added to the accumulator. When the sum is at least the denominator, a tick is issued and the denominator is subtracted. If the numerator is larger than the denominator, every unfrozen cycle ticks and the accumulator is cleared.
- R4: The register map is:
  - 0x10: the counter, read and write.
  - 0x14: the ratio word, read and write. Bits [31:16] are ignored on write and read as 0.
  - 0x4C: freeze in bit 0, read and write.
  - Any other address reads 0, and writes to it change nothing.
  - rd_data_o is loaded one cycle after rd_en_i and holds its value when no read is made.
- R5: While freeze is 1, the accumulator and the counter hold their values and no tick is issued.
- R6: A write to the ratio word clears the accumulator. No tick is issued in the cycle of that write.
- R7: A write to the counter loads the written value. It takes priority over a tick in the same cycle.
- R8: The counter wraps from 0xFFFFFFFF to 0.
- R9: With ratio word 0x045F (5/96), exactly 5 ticks occur in any 96 unfrozen cycles that follow the ratio write.
- R10: A read and a write to the same address in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read request |
| wr_en_i | input | 1 | Write request |
| addr_i | input | 8 | Register byte offset |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| tick_o | output | 1 | One-cycle microsecond tick |

## Verification
A write or a read that is presented before a clock edge takes effect at that edge, so its result appears on rd_data_o in the next cycle. A tick shows on tick_o and in the counter at the edge where the accumulator overflows, and a freeze or ratio write acts from the edge at which it is written. The bench drives inputs on the falling edge and steps a cycle-level model with the same inputs. On the next falling edge it compares tick_o and rd_data_o with the model, so every expected value is sampled exactly one edge after its cause. The directed sections measure counter differences between two reads whose spacing is counted out in edges: 96 edges for the 5/96 ratio, and consecutive reads for the wrap case.

// File: rtl/ustb_pkg.sv
package ustb_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;

  localparam int OFS_COUNT  = 'h10;
  localparam int OFS_RATIO  = 'h14;
  localparam int OFS_FREEZE = 'h4C;

  typedef struct packed {
    logic [FIELD_W-1:0] num_m1;
    logic [FIELD_W-1:0] den_m1;
  } ratio_cfg_t;
endpackage

// File: rtl/ustb_ratio_accum.sv
module ustb_ratio_accum
  import ustb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  ratio_cfg_t cfg_i,
  input  logic       hold_i,
  input  logic       clr_i,
  output logic       step_o,
  output logic       tick_o
);
  localparam int ACC_W = FIELD_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, num, den, sum;
  logic             over;

  assign num  = ACC_W'(cfg_i.num_m1) + ACC_W'(1);
  assign den  = ACC_W'(cfg_i.den_m1) + ACC_W'(1);
  assign sum  = acc_q + num;
  assign over = num > den;

  always_comb begin
    step_o = 1'b0;
    acc_d  = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (!hold_i) begin
      if (over) begin
        step_o = 1'b1;
        acc_d  = '0;
      end else if (sum >= den) begin
        step_o = 1'b1;
        acc_d  = sum - den;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_o <= step_o;
    end
  end

  AST_ACC_BELOW_DEN: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_q < den); // R3
  AST_NO_TICK_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_i && !clr_i) |=> (!tick_o && acc_q == $past(acc_q))); // R5
  AST_CLEAR_ON_CFG: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (acc_q == '0 && !tick_o)); // R6
endmodule

// File: rtl/ustb_counter.sv
module ustb_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= cnt_o + CNT_W'(1);
  end

  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (rst_i)
    (inc_i && !load_i) |=> cnt_o == $past(cnt_o) + CNT_W'(1)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> cnt_o == $past(load_val_i)); // R7
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!inc_i && !load_i) |=> $stable(cnt_o)); // R5
endmodule

// File: rtl/ustb_regs.sv
module ustb_regs
  import ustb_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 32,
  parameter int               CNT_W     = 32,
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rd_data_o,
  output ratio_cfg_t        cfg_o,
  output logic              freeze_o,
  output logic              cfg_wr_o,
  output logic              cnt_load_o,
  output logic [CNT_W-1:0]  cnt_val_o
);
  logic              hit_cnt, hit_cfg, hit_frz;
  logic [DATA_W-1:0] rd_mux;

  assign hit_cnt    = addr_i == ADDR_W'(OFS_COUNT);
  assign hit_cfg    = addr_i == ADDR_W'(OFS_RATIO);
  assign hit_frz    = addr_i == ADDR_W'(OFS_FREEZE);
  assign cfg_wr_o   = wr_en_i && hit_cfg;
  assign cnt_load_o = wr_en_i && hit_cnt;
  assign cnt_val_o  = wr_data_i[CNT_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (hit_cnt)      rd_mux = DATA_W'(cnt_i);
    else if (hit_cfg) rd_mux = DATA_W'(cfg_o);
    else if (hit_frz) rd_mux = DATA_W'(freeze_o);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_o     <= ratio_cfg_t'(RESET_CFG);
      freeze_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (rd_en_i)                cfg_o <= cfg_o;
      if (rd_en_i)                rd_data_o <= rd_mux;
      if (cfg_wr_o)               cfg_o <= ratio_cfg_t'(wr_data_i[CFG_W-1:0]);
      if (wr_en_i && hit_frz)     freeze_o <= wr_data_i[0];
    end
  end

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_wr_o |=> cfg_o == ratio_cfg_t'($past(wr_data_i[CFG_W-1:0]))); // R4
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rd_data_o)); // R4
endmodule

// File: rtl/ustb_timebase.sv
module ustb_timebase
  import ustb_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 32,
  parameter int               CNT_W     = 32,
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tick_o
);
  ratio_cfg_t       cfg;
  logic             freeze, cfg_wr, cnt_load, step;
  logic [CNT_W-1:0] cnt, cnt_val;

  ustb_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_CFG(RESET_CFG)
  ) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .cnt_i(cnt),
    .rd_data_o(rd_data_o), .cfg_o(cfg), .freeze_o(freeze),
    .cfg_wr_o(cfg_wr), .cnt_load_o(cnt_load), .cnt_val_o(cnt_val)
  );

  ustb_ratio_accum u_accum (
    .clk_i(clk_i), .rst_i(rst_i), .cfg_i(cfg), .hold_i(freeze),
    .clr_i(cfg_wr), .step_o(step), .tick_o(tick_o)
  );

  ustb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .inc_i(step), .load_i(cnt_load),
    .load_val_i(cnt_val), .cnt_o(cnt)
  );

  AST_TICK_ADVANCES: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && !cnt_load) |=> (tick_o && cnt == $past(cnt) + CNT_W'(1))); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && !cnt_load && cnt == '1) |=> cnt == '0); // R8
endmodule

// File: tb/tb_ustb_timebase.sv
module tb_ustb_timebase;
  localparam logic [7:0] A_CNT = 8'h10, A_CFG = 8'h14, A_FRZ = 8'h4C;

  logic        clk = 1'b0, rst = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        tick;

  ustb_timebase dut (
    .clk_i(clk), .rst_i(rst), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wr_data), .rd_data_o(rd_data), .tick_o(tick)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic        done = 1'b0;
  logic [31:0] m_cnt = '0, m_rd = '0;
  int          m_acc = 0, m_num_m1 = 0, m_den_m1 = 11;
  logic        m_frz = 1'b0, m_tick = 1'b0;
  string       m_tag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      A_CNT:   return m_cnt;
      A_CFG:   return {16'h0, 8'(m_num_m1), 8'(m_den_m1)};
      A_FRZ:   return {31'h0, m_frz};
      default: return 32'h0;
    endcase
  endfunction

  // R3: one accumulator step; returns tick, updates acc
  function automatic logic ratio_step(inout int acc, input int num, input int den);
    if (num > den) begin acc = 0; return 1'b1; end
    if (acc + num >= den) begin acc = acc + num - den; return 1'b1; end
    acc = acc + num;
    return 1'b0;
  endfunction

  task automatic step(input logic r, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    logic tk;
    chk("R2 tick", {31'h0, tick}, {31'h0, m_tick});
    chk(m_tag, rd_data, m_rd);
    if (r) begin m_rd = model_read(a); m_tag = tag; end
    if (w && a == A_CFG) begin m_acc = 0; tk = 1'b0; end   // R6
    else if (m_frz) tk = 1'b0;                              // R5
    else tk = ratio_step(m_acc, m_num_m1 + 1, m_den_m1 + 1);
    if (w && a == A_CNT) m_cnt = d;                         // R7
    else if (tk) m_cnt = m_cnt + 32'd1;
    if (w && a == A_CFG) begin m_num_m1 = int'(d[15:8]); m_den_m1 = int'(d[7:0]); end
    if (w && a == A_FRZ) m_frz = d[0];
    m_tick = tk;
    rd_en = r; wr_en = w; addr = a; wr_data = d;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v0, v1;
    int tick_cnt;
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rd", rd_data, 32'h0);
    chk("R1 tick", {31'h0, tick}, 32'h0);
    step(1, 0, A_CFG, 0, "R1");
    step(1, 0, A_FRZ, 0, "R1");
    step(1, 0, A_CNT, 0, "R1");
    step(1, 1, 8'h20, 32'hDEAD, "R4");

    // R9: 5/96 ratio
    step(0, 1, A_CFG, 32'hABCD_045F, "R9");
    step(1, 0, A_CNT, 0, "R9");
    v0 = rd_data;
    tick_cnt = 0;
    for (int i = 0; i < 95; i++) begin
      step(0, 0, A_CNT, 0, "R9");
      tick_cnt += int'(tick);
    end
    step(1, 0, A_CNT, 0, "R9");
    v1 = rd_data;
    chk("R9 delta", v1 - v0, 32'd5);
    step(1, 0, A_CFG, 0, "R4");

    // R8 wrap with tick every cycle
    step(0, 1, A_CFG, 32'h0000, "R8");
    step(0, 1, A_CNT, 32'hFFFF_FFFF, "R7");
    step(1, 0, A_CNT, 0, "R8");
    chk("R8 before", rd_data, 32'hFFFF_FFFF);
    step(1, 0, A_CNT, 0, "R8");
    chk("R8 wrap", rd_data, 32'h0);

    // R7 load beats tick
    step(0, 1, A_CNT, 32'h100, "R7");
    step(1, 0, A_CNT, 0, "R7");
    chk("R7 load", rd_data, 32'h100);

    // R10 read and write same address
    step(1, 1, A_CNT, 32'h55, "R10");
    step(1, 1, A_CFG, 32'h0303, "R10");
    step(1, 1, A_FRZ, 32'h0, "R10");

    // R5 freeze
    step(0, 1, A_FRZ, 32'h1, "R5");
    step(1, 0, A_CNT, 0, "R5");
    v0 = rd_data;
    for (int i = 0; i < 10; i++) step(0, 0, A_CNT, 0, "R5");
    step(1, 0, A_CNT, 0, "R5");
    chk("R5 frozen", rd_data, v0);
    step(0, 1, A_FRZ, 32'h0, "R5");

    // R6 ratio write clears phase
    step(0, 1, A_CFG, 32'h0263, "R6");
    for (int i = 0; i < 40; i++) step(i % 3 == 0, 0, A_CNT, 0, "R6");

    // R3 random mix
    for (int i = 0; i < 3000; i++) begin
      logic r, w;
      logic [7:0] a;
      logic [31:0] d;
      int sel;
      r = 1'($urandom % 2);
      w = ($urandom % 10) == 0;
      sel = int'($urandom % 5);
      a = (sel == 0) ? A_CNT : (sel == 1) ? A_CFG : (sel == 2) ? A_FRZ :
          (sel == 3) ? 8'h18 : 8'h00;
      d = $urandom;
      if (a == A_CFG && ($urandom % 4) != 0) begin
        d[7:0]  = 8'($urandom % 200) + 8'd10;
        d[15:8] = 8'($urandom % (int'(d[7:0]) + 1));
      end
      if (a == A_FRZ) d[0] = ($urandom % 4) == 0;
      if (a == A_CNT && d[0]) d = 32'hFFFF_FFF0 | d[3:0];
      step(r, w, a, d, "R3");
    end
    step(0, 1, A_FRZ, 32'h0, "R3");
    step(1, 0, A_CNT, 0, "R3");
    step(0, 0, A_CNT, 0, "R3");
    chk("R2 tick final", {31'h0, tick}, {31'h0, m_tick});
    chk("R3 final", rd_data, m_rd);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule